// File: doc/BRIEF.md
# Oversampled Serial Receiver with Two-Deep Buffer and Status Word

This block receives 8N1 asynchronous serial characters on one input line. A 16x sample tick comes from outside the block. The receiver finds the falling edge of a start bit and confirms it at mid-bit. It then samples eight data bits, least significant first, and checks the stop bit. Each finished character goes into a two-entry buffer. The frame-error and overrun status of each character is stored with it, so the status always describes the character that will be read next.

When both buffer entries are full, one more finished character waits in a holding register. It moves into the buffer in the cycle after an entry frees. If yet another start bit arrives while the buffer is full and a character is waiting, the waiting character is marked with overrun and the new frame is thrown away.

Software reads the oldest character through a byte-wide port with a pop strobe. It reads a status word that shows data available, frame error and overrun, and it can write an interrupt enable bit. An interrupt request is raised while data is available and the enable is set. Dropping the receiver enable flushes all stored characters.

Top module: `uart_rx_status`

## Requirements
- R1: After reset the buffer is empty, the status word reads 0x00 and irq is low.
- R2: A low level on the line begins a start bit only if the line is still low 8 ticks later, at mid-bit. Otherwise the receiver returns to idle and stores nothing.
- R3: One bit lasts 16 ticks of the sample input, and clock cycles without a tick do not count. Data bits are sampled at mid-bit and assembled least significant bit first.
- R4: Finished characters are read back in arrival order. Each read pops one character. Status bit 7 is 1 exactly while at least one unread character is buffered.
- R5: Status bit 4 is 1 when the character at the head of the buffer had its stop bit sampled as 0, and 0 when its stop bit was 1.
- R6: A third character that finishes while two are buffered is kept in a holding register. It enters the buffer after a read frees an entry, and it is not lost.
- R7: A start bit that is detected while two characters are buffered and one is waiting sets the overrun mark on the waiting character. That mark appears as status bit 3 when the character reaches the head. The incoming frame is discarded.
- R8: A status write takes only bit 0, the interrupt enable. Bits 7, 4 and 3 are not changed by the write.
- R9: irq equals status bit 7 AND status bit 0.
- R10: Driving rx_en low empties the buffer and the holding register, clears bit 7, and stops reception.
- R11: A read strobe while the buffer is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Sample tick at 16 times the bit rate |
| rxd | input | 1 | Serial line; idles high |
| rx_en | input | 1 | Receiver enable; low flushes the buffer |
| rd_en | input | 1 | Pops the head character |
| rd_data | output | 8 | Head character; 0 when empty |
| stat_wr | input | 1 | Status word write strobe |
| stat_wdata | input | 8 | Status write data; only bit 0 is used |
| stat_rdata | output | 8 | Bit 7 available, bit 4 frame error, bit 3 overrun, bit 0 interrupt enable |
| irq | output | 1 | Receive-complete interrupt request |

## Verification
The bench sends forty byte values spread over the whole range, with a tick on every second clock. A receiver that counted clocks instead of ticks, or that shifted most significant bit first, returns the wrong bytes. It sends a short low glitch, which a receiver without mid-bit confirmation would turn into a spurious 0xFF. It runs frame error followed by a good frame, and then three and four back-to-back frames with no reads. A design that kept flags globally instead of per character, dropped the waiting character, or stored the discarded fourth frame would show the wrong flags or extra data. Status writes of all ones and the flush through rx_en close the run.

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick16,
  input  logic          rxd,
  input  logic          rx_en,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic          stat_wr,
  input  logic [7:0]    stat_wdata,
  output logic [7:0]    stat_rdata,
  output logic          irq
);
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(DW);
  localparam int EW = DW + 2;

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bidx;
  logic [DW-1:0] sh;
  logic          drop;
  logic [EW-1:0] e0, e1, hold;
  logic          hold_v;
  logic [1:0]    fcnt;
  logic          ie;

  wire full      = (fcnt == 2'd2);
  wire avail     = (fcnt != 2'd0);
  wire done      = tick16 && (st == S_STOP) && (cnt == CW'(OVS-1));
  wire start_det = tick16 && (st == S_IDLE) && !rxd;
  wire pop       = rd_en && avail;
  wire push_hold = hold_v && !full;
  wire push_new  = done && !drop && !hold_v && !full;
  wire push      = push_hold || push_new;
  wire [EW-1:0] new_ent = {1'b0, !rxd, sh};
  wire [EW-1:0] pd      = hold_v ? hold : new_ent;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; bidx <= '0; sh <= '0; drop <= 1'b0;
      e0 <= '0; e1 <= '0; hold <= '0; hold_v <= 1'b0; fcnt <= 2'd0;
    end else if (!rx_en) begin
      st <= S_IDLE; cnt <= '0; bidx <= '0; drop <= 1'b0;
      hold_v <= 1'b0; fcnt <= 2'd0;
    end else begin
      if (tick16) begin
        case (st)
          S_IDLE: if (!rxd) begin
            st   <= S_START;
            cnt  <= '0;
            drop <= full && hold_v;
          end
          S_START: begin
            if (cnt == CW'(OVS/2 - 1)) begin
              st   <= rxd ? S_IDLE : S_DATA;
              cnt  <= '0;
              bidx <= '0;
            end else cnt <= cnt + 1'b1;
          end
          S_DATA: begin
            if (cnt == CW'(OVS-1)) begin
              cnt  <= '0;
              sh   <= {rxd, sh[DW-1:1]};
              bidx <= bidx + 1'b1;
              if (bidx == BW'(DW-1)) st <= S_STOP;
            end else cnt <= cnt + 1'b1;
          end
          S_STOP: begin
            if (cnt == CW'(OVS-1)) begin
              st  <= S_IDLE;
              cnt <= '0;
            end else cnt <= cnt + 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end

      if (done && !drop && !hold_v && full) begin
        hold   <= new_ent;
        hold_v <= 1'b1;
      end else if (push_hold) begin
        hold_v <= 1'b0;
      end else if (start_det && full && hold_v) begin
        hold[EW-1] <= 1'b1;
      end

      case ({push, pop})
        2'b11: begin
          if (fcnt == 2'd1) e0 <= pd;
          else begin e0 <= e1; e1 <= pd; end
        end
        2'b01: begin e0 <= e1; fcnt <= fcnt - 1'b1; end
        2'b10: begin
          if (fcnt == 2'd0) e0 <= pd; else e1 <= pd;
          fcnt <= fcnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ie <= 1'b0;
    else if (stat_wr) ie <= stat_wdata[0];
  end

  assign rd_data    = avail ? e0[DW-1:0] : '0;
  assign stat_rdata = {avail, 2'b00, avail & e0[DW], avail & e0[DW+1], 2'b00, ie};
  assign irq        = avail & ie;
endmodule

module uart_rx_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_en,
  input logic       rd_en,
  input logic       stat_wr,
  input logic [7:0] stat_rdata,
  input logic       irq
);
  a_r9_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (stat_rdata[7] & stat_rdata[0]));
  a_r10_flush: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !stat_rdata[7]);
  a_r5_fe_only_with_data: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rdata[4] |-> stat_rdata[7]);
  a_r7_ovr_only_with_data: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rdata[3] |-> stat_rdata[7]);
  a_r4_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rdata[7] && !rd_en && rx_en) |=> stat_rdata[7]);
  a_r8_write_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && rx_en && !rd_en && stat_rdata[7]) |=> $stable(stat_rdata[4:3]));
endmodule

bind uart_rx_status uart_rx_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rd_en(rd_en),
  .stat_wr(stat_wr), .stat_rdata(stat_rdata), .irq(irq)
);

// File: tb/tb_uart_rx_status.sv
module tb_uart_rx_status;
  logic clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0, rxd = 1'b1, rx_en = 1'b0;
  logic rd_en = 1'b0, stat_wr = 1'b0;
  logic [7:0] stat_wdata = 8'h00;
  logic [7:0] rd_data, stat_rdata;
  logic irq;
  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;
  always @(negedge clk) tick16 <= ~tick16;

  uart_rx_status dut (.clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
    .rx_en(rx_en), .rd_en(rd_en), .rd_data(rd_data), .stat_wr(stat_wr),
    .stat_wdata(stat_wdata), .stat_rdata(stat_rdata), .irq(irq));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold_line(input logic v, input int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input logic stopv);
    @(negedge clk);
    hold_line(1'b0, 32);
    for (int i = 0; i < 8; i++) hold_line(b[i], 32);
    hold_line(stopv, 32);
    hold_line(1'b1, 64);
  endtask

  task automatic pop_one();
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic expect_head(input string req, input logic [7:0] d, input logic [7:0] st);
    chk(rd_data == d, req, rd_data, d);
    chk(stat_rdata == st, req, stat_rdata, st);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(stat_rdata == 8'h00 && !irq, "R1", stat_rdata, 0);
    rst_n = 1'b1; rx_en = 1'b1;
    repeat (4) @(negedge clk);
    chk(stat_rdata == 8'h00 && rd_data == 8'h00, "R1", stat_rdata, 0);

    // R2 short glitch ignored
    @(negedge clk); hold_line(1'b0, 12); hold_line(1'b1, 96);
    chk(stat_rdata[7] == 1'b0, "R2 glitch", stat_rdata, 0);

    // R3 R4 sweep of byte values
    for (int i = 0; i < 40; i++) begin
      logic [7:0] v;
      v = 8'((i * 37 + 11) & 255);
      send(v, 1'b1);
      expect_head("R3 R4 sweep", v, 8'h80);
      pop_one();
      chk(stat_rdata[7] == 1'b0, "R4 empty after pop", stat_rdata, 0);
    end

    // R11 read when empty
    pop_one();
    chk(stat_rdata == 8'h00 && rd_data == 8'h00, "R11", stat_rdata, 0);

    // R5 frame error travels with character
    send(8'h3C, 1'b0);
    send(8'hC3, 1'b1);
    expect_head("R5 bad stop", 8'h3C, 8'h90);
    // R8 write all ones: only enable changes
    @(negedge clk); stat_wr = 1'b1; stat_wdata = 8'hFF;
    @(negedge clk); stat_wr = 1'b0;
    @(negedge clk);
    chk(stat_rdata == 8'h91, "R8 write ignored flags", stat_rdata, 8'h91);
    chk(irq == 1'b1, "R9 irq on", irq, 1);
    pop_one();
    expect_head("R5 good stop", 8'hC3, 8'h81);
    pop_one();
    chk(irq == 1'b0, "R9 irq off when empty", irq, 0);
    @(negedge clk); stat_wr = 1'b1; stat_wdata = 8'h00;
    @(negedge clk); stat_wr = 1'b0;

    // R6 third character held, order kept
    send(8'h11, 1'b1); send(8'h22, 1'b1); send(8'h33, 1'b1);
    expect_head("R6 head", 8'h11, 8'h80);
    pop_one(); expect_head("R6 second", 8'h22, 8'h80);
    pop_one(); expect_head("R6 held char", 8'h33, 8'h80);
    pop_one();
    chk(stat_rdata[7] == 1'b0, "R6 drained", stat_rdata, 0);

    // R7 overrun: fourth start marks the waiting char, fourth frame lost
    send(8'h44, 1'b1); send(8'h55, 1'b1); send(8'h66, 1'b1); send(8'h77, 1'b1);
    expect_head("R7 head clean", 8'h44, 8'h80);
    pop_one(); expect_head("R7 second clean", 8'h55, 8'h80);
    pop_one(); expect_head("R7 marked", 8'h66, 8'h88);
    pop_one();
    chk(stat_rdata[7] == 1'b0, "R7 frame discarded", stat_rdata, 0);

    // R10 flush
    send(8'hA1, 1'b1); send(8'hB2, 1'b1); send(8'hC3, 1'b1);
    @(negedge clk); stat_wr = 1'b1; stat_wdata = 8'h01;
    @(negedge clk); stat_wr = 1'b0; rx_en = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(stat_rdata == 8'h01 && !irq, "R10 flush", stat_rdata, 8'h01);
    send(8'h5A, 1'b1);
    chk(stat_rdata[7] == 1'b0, "R10 disabled ignores line", stat_rdata, 0);
    rx_en = 1'b1;
    repeat (4) @(negedge clk);
    chk(stat_rdata[7] == 1'b0, "R10 holding cleared", stat_rdata, 0);
    send(8'h96, 1'b1);
    expect_head("R10 resumes", 8'h96, 8'h81);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule